// File: doc/BRIEF.md
# Vectored Interrupt Controller with Wake-up

This block sits beside a small processor core and decides which interrupt vector the core should take next. Every vector has a request flag and an enable bit, and a single global enable gates all of them. The first vectors are driven straight from peripheral set strobes. One shared vector serves a serial module and is raised by any of its status conditions. One multi-function vector stands in for a group of member sources, and each member has its own flag and enable. The core is told about the winning vector through a request valid and a vector index. It acknowledges service with a strobe. It ends service with either a return that re-enables interrupts or a plain return.

When the core acknowledges a vector, the controller clears that vector's flag and drops the global enable. Only a return-with-enable raises the global enable again. A flag that is pending but not enabled stays pending until it is serviced or until software clears it. The controller also gives a one-cycle wake-up pulse whenever any flag, vector or member, rises from 0 to 1. The enables do not gate this pulse, so sleep and idle logic can use it directly. All flags and enables can be read and written through a small register port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every vector flag, vector enable, member flag, member enable and the global enable read 0, `reqValid` is 0 and `wakeUp` is 0.
- R2: `reqValid` is 1 only while the global enable is 1, `stackFull` is 0 and at least one vector has both its flag and its enable set.
- R3: When several enabled vectors are pending, `reqVec` gives the lowest index among them.
- R4: `ackSvc` while `reqValid` is 1 clears the flag of the vector shown on `reqVec` and clears the global enable, at the same clock edge.
- R5: A set flag stays set while its enable is 0 and while no request is taken. Writing 0 to it through the register port clears it.
- R6: Vector index NDIRECT+1 is the group vector. A member set strobe always sets that member's flag. It also sets the group flag only if that member's enable is 1. Servicing the group vector clears only the group flag, and the member flags keep their values.
- R7: Vector index NDIRECT is the serial vector. Its flag is set at any edge where any of the `serialCond` lines is 1, whichever line it is.
- R8: `wakeUp` is 1 for exactly the one cycle after an edge at which any vector or member flag went from 0 to 1, whatever the enables hold. A set strobe to a flag that is already 1 produces no pulse.
- R9: `retEnable` sets the global enable to 1. `retPlain` leaves it unchanged.
- R10: A hardware set beats a register write of 0 and a service clear in the same cycle, so the flag ends up 1.
- R11: Register map on `swAddr`: 0 holds the vector flags in bits [NDIRECT+1:0], 1 the vector enables, 2 the member flags in bits [NMEMBER-1:0], 3 the member enables, and 4 the global enable in bit 0. A write takes effect at the clock edge. `swRdData` follows `swAddr` combinationally, and bits beyond each field read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwSetDirect | input | NDIRECT | Set strobes for the direct vectors 0..NDIRECT-1 |
| serialCond | input | NSERIAL | Serial module status conditions, any of which raises the serial vector |
| memberSet | input | NMEMBER | Set strobes for the group member flags |
| stackFull | input | 1 | Core reports that its return stack has no room |
| ackSvc | input | 1 | Core takes the requested vector |
| retEnable | input | 1 | Return that restores the global enable |
| retPlain | input | 1 | Return that leaves the global enable alone |
| swWrEn | input | 1 | Register write strobe |
| swAddr | input | 3 | Register address for read and write |
| swWrData | input | DATA_W | Register write data |
| swRdData | output | DATA_W | Register read data |
| reqValid | output | 1 | A vector request is being presented |
| reqVec | output | VEC_W | Index of the requested vector |
| wakeUp | output | 1 | One-cycle pulse on any flag rising |

## Verification
A flag that sets or clears wrongly shows up on the read port in the same cycle that `swAddr` selects it. It also shows up on `reqValid` and `reqVec` as soon as that vector is enabled and the global enable is 1. A global enable left in the wrong state after an acknowledge or a return shows up as a request that stays present or fails to appear one cycle later. A broken edge detector shows as a missing or doubled `wakeUp` cycle right after the set edge. The directed tests therefore read the registers back and probe the request outputs after every step, rather than only at the end of a scenario.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam logic [2:0] ADDR_FLAGS  = 3'd0;
  localparam logic [2:0] ADDR_VEN    = 3'd1;
  localparam logic [2:0] ADDR_MFLAGS = 3'd2;
  localparam logic [2:0] ADDR_MEN    = 3'd3;
  localparam logic [2:0] ADDR_GIE    = 3'd4;

  // strobes from the arbiter to the flag datapath
  typedef struct packed {
    logic       svcValid;
    logic [7:0] svcVec;
  } svcStrobe_t;
endpackage

// File: rtl/irq_flag_path.sv
module irq_flag_path
  import irq_vec_pkg::*;
#(
  parameter int NDIRECT = 3,
  parameter int NSERIAL = 6,
  parameter int NMEMBER = 4,
  parameter int DATA_W  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NDIRECT-1:0] hwSetDirect,
  input  logic [NSERIAL-1:0] serialCond,
  input  logic [NMEMBER-1:0] memberSet,
  input  logic               swWrEn,
  input  logic [2:0]         swAddr,
  input  logic [DATA_W-1:0]  swWrData,
  input  logic               gie,
  input  svcStrobe_t         strobes,
  output logic [NDIRECT+1:0] pending,
  output logic [DATA_W-1:0]  swRdData,
  output logic               wakeUp
);
  localparam int NVEC = NDIRECT + 2;
  localparam int NALL = NVEC + NMEMBER;

  logic [NVEC-1:0]    vecFlag, vecEn, hwSetVec, svcClr;
  logic [NMEMBER-1:0] memFlag, memEn;
  logic [NALL-1:0]    prevAll;
  logic               armed;
  logic               wrFlags, wrVen, wrMflags, wrMen;

  assign wrFlags  = swWrEn && (swAddr == ADDR_FLAGS);
  assign wrVen    = swWrEn && (swAddr == ADDR_VEN);
  assign wrMflags = swWrEn && (swAddr == ADDR_MFLAGS);
  assign wrMen    = swWrEn && (swAddr == ADDR_MEN);

  // set sources per vector: direct, then serial, then group
  assign hwSetVec = {|(memberSet & memEn), |serialCond, hwSetDirect};

  for (genvar v = 0; v < NVEC; v++) begin : g_clr
    assign svcClr[v] = strobes.svcValid && (strobes.svcVec == 8'(v));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecFlag <= '0;
      vecEn   <= '0;
      memFlag <= '0;
      memEn   <= '0;
      prevAll <= '0;
      armed   <= 1'b0;
    end else begin
      vecFlag <= hwSetVec | (wrFlags ? swWrData[NVEC-1:0] : (vecFlag & ~svcClr));
      memFlag <= memberSet | (wrMflags ? swWrData[NMEMBER-1:0] : memFlag);
      if (wrVen) vecEn <= swWrData[NVEC-1:0];
      if (wrMen) memEn <= swWrData[NMEMBER-1:0];
      prevAll <= {memFlag, vecFlag};
      armed   <= 1'b1;
    end
  end

  assign wakeUp  = armed && |({memFlag, vecFlag} & ~prevAll);
  assign pending = vecFlag & vecEn;

  always_comb begin
    swRdData = '0;
    case (swAddr)
      ADDR_FLAGS:  swRdData[NVEC-1:0]    = vecFlag;
      ADDR_VEN:    swRdData[NVEC-1:0]    = vecEn;
      ADDR_MFLAGS: swRdData[NMEMBER-1:0] = memFlag;
      ADDR_MEN:    swRdData[NMEMBER-1:0] = memEn;
      ADDR_GIE:    swRdData[0]           = gie;
      default:     swRdData              = '0;
    endcase
  end

  // R5: with no write and no service, no set flag drops
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!wrFlags && !strobes.svcValid) |=> ((vecFlag & $past(vecFlag)) == $past(vecFlag)));

  // R4 / R10: a serviced flag is clear next cycle unless set again
  a_r4_svc_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.svcValid && !wrFlags) |=> ((vecFlag & $past(svcClr) & ~$past(hwSetVec)) == '0));

  // R8: a wake pulse implies some flag is up
  a_r8_wake_has_flag: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |-> ({memFlag, vecFlag} != '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_vec_pkg::*;
#(
  parameter int NVEC  = 5,
  parameter int VEC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NVEC-1:0]  pending,
  input  logic             stackFull,
  input  logic             ackSvc,
  input  logic             retEnable,
  input  logic             retPlain,
  input  logic             gieWr,
  input  logic             gieWrVal,
  output logic             reqValid,
  output logic [VEC_W-1:0] reqVec,
  output logic             gie,
  output svcStrobe_t       strobes
);
  logic found;
  logic take;

  // fixed priority, lowest index first
  always_comb begin
    found  = 1'b0;
    reqVec = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found  = 1'b1;
        reqVec = VEC_W'(i);
      end
    end
  end

  assign reqValid = gie && !stackFull && found;
  assign take     = ackSvc && reqValid;

  assign strobes.svcValid = take;
  assign strobes.svcVec   = 8'(reqVec);

  always_ff @(posedge clk) begin
    if (!rstN)          gie <= 1'b0;
    else if (take)      gie <= 1'b0;
    else if (retEnable) gie <= 1'b1;
    else if (gieWr)     gie <= gieWrVal;
  end

  a_r2_req_gated: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (gie && !stackFull && pending[reqVec]));

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((pending & ((NVEC'(1) << reqVec) - NVEC'(1))) == '0));

  a_r4_ack_drops_gie: assert property (@(posedge clk) disable iff (!rstN)
    (ackSvc && reqValid) |=> !gie);

  a_r9_reti_sets: assert property (@(posedge clk) disable iff (!rstN)
    (retEnable && !(ackSvc && reqValid)) |=> gie);

  a_r9_plain_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (retPlain && !retEnable && !ackSvc && !gieWr) |=> $stable(gie));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int NDIRECT = 3,
  parameter int NSERIAL = 6,
  parameter int NMEMBER = 4,
  parameter int DATA_W  = ((NDIRECT + 2) > NMEMBER) ? (NDIRECT + 2) : NMEMBER,
  parameter int VEC_W   = $clog2(NDIRECT + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NDIRECT-1:0] hwSetDirect,
  input  logic [NSERIAL-1:0] serialCond,
  input  logic [NMEMBER-1:0] memberSet,
  input  logic               stackFull,
  input  logic               ackSvc,
  input  logic               retEnable,
  input  logic               retPlain,
  input  logic               swWrEn,
  input  logic [2:0]         swAddr,
  input  logic [DATA_W-1:0]  swWrData,
  output logic [DATA_W-1:0]  swRdData,
  output logic               reqValid,
  output logic [VEC_W-1:0]   reqVec,
  output logic               wakeUp
);
  localparam int NVEC = NDIRECT + 2;

  logic [NVEC-1:0] pending;
  logic            gie;
  svcStrobe_t      strobes;

  irq_flag_path #(
    .NDIRECT(NDIRECT), .NSERIAL(NSERIAL), .NMEMBER(NMEMBER), .DATA_W(DATA_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .hwSetDirect(hwSetDirect), .serialCond(serialCond),
    .memberSet(memberSet), .swWrEn(swWrEn), .swAddr(swAddr), .swWrData(swWrData),
    .gie(gie), .strobes(strobes), .pending(pending), .swRdData(swRdData),
    .wakeUp(wakeUp)
  );

  irq_arbiter #(.NVEC(NVEC), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rstN(rstN), .pending(pending), .stackFull(stackFull),
    .ackSvc(ackSvc), .retEnable(retEnable), .retPlain(retPlain),
    .gieWr(swWrEn && (swAddr == ADDR_GIE)), .gieWrVal(swWrData[0]),
    .reqValid(reqValid), .reqVec(reqVec), .gie(gie), .strobes(strobes)
  );
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] hwSetDirect;
  logic [5:0] serialCond;
  logic [3:0] memberSet;
  logic       stackFull, ackSvc, retEnable, retPlain, swWrEn;
  logic [2:0] swAddr;
  logic [4:0] swWrData;
  logic [4:0] swRdData;
  logic       reqValid;
  logic [2:0] reqVec;
  logic       wakeUp;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rstN(rstN), .hwSetDirect(hwSetDirect), .serialCond(serialCond),
    .memberSet(memberSet), .stackFull(stackFull), .ackSvc(ackSvc),
    .retEnable(retEnable), .retPlain(retPlain), .swWrEn(swWrEn), .swAddr(swAddr),
    .swWrData(swWrData), .swRdData(swRdData), .reqValid(reqValid),
    .reqVec(reqVec), .wakeUp(wakeUp)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [4:0] d);
    swWrEn = 1'b1; swAddr = a; swWrData = d;
    tick();
    swWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    swAddr = a; #1;
    chk(tag, swRdData, exp);
  endtask

  task automatic req(input int v, input int exp, input string tag);
    #1;
    chk({tag, " valid"}, reqValid, v);
    if (v == 1) chk({tag, " vec"}, reqVec, exp);
  endtask

  task automatic pulseAck();
    ackSvc = 1'b1; tick(); ackSvc = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    for (int a = 0; a < 5; a++) rd(3'(a), 0, "R1 reset register");
    req(0, 0, "R1 reset request");
    chk("R1 reset wake", wakeUp, 0);
  endtask

  task automatic testGating();
    hwSetDirect = 3'b001; tick(); hwSetDirect = '0;
    chk("R8 wake on set", wakeUp, 1);
    tick();
    chk("R8 wake one cycle", wakeUp, 0);
    req(0, 0, "R2 no enable");
    wr(3'd1, 5'b00001);
    req(0, 0, "R2 no global enable");
    wr(3'd4, 5'b00001);
    req(1, 0, "R2 all enables");
    stackFull = 1'b1;
    req(0, 0, "R2 stack full");
    stackFull = 1'b0;
    pulseAck();
    rd(3'd0, 0, "R4 flag cleared by ack");
    rd(3'd4, 0, "R4 global enable cleared");
    req(0, 0, "R4 no request after ack");
  endtask

  task automatic testPriority();
    wr(3'd1, 5'b00111);
    hwSetDirect = 3'b101; tick(); hwSetDirect = '0;
    retEnable = 1'b1; tick(); retEnable = 1'b0;
    rd(3'd4, 1, "R9 return-with-enable");
    req(1, 0, "R3 lowest of 0 and 2");
    pulseAck();
    rd(3'd0, 5'b00100, "R4 only vector 0 cleared");
    req(0, 0, "R4 global enable off");
    retPlain = 1'b1; tick(); retPlain = 1'b0;
    rd(3'd4, 0, "R9 plain return keeps 0");
    req(0, 0, "R9 plain return no request");
    retEnable = 1'b1; tick(); retEnable = 1'b0;
    req(1, 2, "R3 next pending vector");
    pulseAck();
    rd(3'd0, 0, "R4 vector 2 cleared");
  endtask

  task automatic testPersist();
    wr(3'd1, 5'b00000);
    hwSetDirect = 3'b010; tick(); hwSetDirect = '0;
    repeat (5) tick();
    rd(3'd0, 5'b00010, "R5 flag held while disabled");
    wr(3'd4, 5'b00001);
    req(0, 0, "R5 disabled flag no request");
    wr(3'd0, 5'b00000);
    rd(3'd0, 0, "R5 software clear");
    wr(3'd4, 5'b00000);
  endtask

  task automatic testGroup();
    wr(3'd3, 5'b00001);
    memberSet = 4'b0010; tick(); memberSet = '0;
    chk("R8 wake ignores enables", wakeUp, 1);
    rd(3'd2, 4'b0010, "R6 member flag set");
    rd(3'd0, 0, "R6 disabled member leaves group");
    memberSet = 4'b0001; tick(); memberSet = '0;
    rd(3'd0, 5'b10000, "R6 enabled member sets group");
    wr(3'd1, 5'b10000);
    wr(3'd4, 5'b00001);
    req(1, 4, "R6 group request");
    pulseAck();
    rd(3'd0, 0, "R6 group flag cleared");
    rd(3'd2, 4'b0011, "R6 member flags kept");
    wr(3'd2, 5'b00000);
    wr(3'd3, 5'b00000);
    wr(3'd1, 5'b00000);
  endtask

  task automatic testSerial();
    for (int i = 0; i < 6; i++) begin
      serialCond = 6'(1 << i); tick(); serialCond = '0;
      rd(3'd0, 5'b01000, "R7 serial condition");
      wr(3'd0, 5'b00000);
    end
    rd(3'd0, 0, "R7 serial cleared");
  endtask

  task automatic testNoEdge();
    hwSetDirect = 3'b001; tick(); hwSetDirect = '0;
    chk("R8 first set wakes", wakeUp, 1);
    tick();
    hwSetDirect = 3'b001; tick(); hwSetDirect = '0;
    chk("R8 already set no wake", wakeUp, 0);
    wr(3'd0, 5'b00000);
  endtask

  task automatic testRace();
    hwSetDirect = 3'b001; tick(); hwSetDirect = '0;
    hwSetDirect = 3'b010;
    wr(3'd0, 5'b00000);
    hwSetDirect = '0;
    rd(3'd0, 5'b00010, "R10 set beats write");
    serialCond = 6'b000001; tick();
    wr(3'd1, 5'b01000);
    wr(3'd4, 5'b00001);
    req(1, 3, "R10 serial request");
    pulseAck();
    serialCond = '0;
    rd(3'd0, 5'b01010, "R10 set beats service clear");
    rd(3'd4, 0, "R10 global enable dropped");
    wr(3'd0, 5'b00000);
    wr(3'd1, 5'b00000);
  endtask

  task automatic testMap();
    wr(3'd1, 5'b11111);
    rd(3'd1, 5'b11111, "R11 enable readback");
    wr(3'd3, 5'b11111);
    rd(3'd3, 5'b01111, "R11 member enable width");
    wr(3'd4, 5'b11110);
    rd(3'd4, 0, "R11 global enable bit 0 only");
    wr(3'd1, 5'b00000);
    wr(3'd3, 5'b00000);
    rd(3'd5, 0, "R11 unmapped address");
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hwSetDirect = '0; serialCond = '0; memberSet = '0;
    stackFull = 1'b0; ackSvc = 1'b0; retEnable = 1'b0; retPlain = 1'b0;
    swWrEn = 1'b0; swAddr = '0; swWrData = '0;
    testReset();
    testGating();
    testPriority();
    testPersist();
    testGroup();
    testSerial();
    testNoEdge();
    testRace();
    testMap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule